// File: doc/BRIEF.md
# Exception Entry Sequencer with Late-Arrival Retargeting

This block sequences how a processor core takes an exception. It watches a vector of pending exception requests, each carrying a configurable priority. It picks the most urgent one and asks an external register-save engine to push the context. It then reads that exception's handler address from a vector table through a simple read port, and finally announces the handler start along with the active exception number and handler address.

Two situations change the flow. First, a more urgent request can appear while the context is still being pushed or while the vector word is being read. In that case the sequencer switches its target to the newer request. It reads the new vector, and a read that is already outstanding is thrown away. The context is not pushed a second time. Second, a more urgent request can appear once the handler-start stage has been reached. That request is handled as a normal preemption, with a fresh context push. Exception number 1 (reset) and number 2 (NMI) have fixed priorities above every configurable level. Some table slots hold no handler and are never chosen.

Top module: `exc_entry_seq`

## Requirements
- R1: After a synchronous reset, `stk_req`, `mem_ren`, `hstart` and `act_valid` are all 0.
- R2: Among pending usable requests, the winner has the smallest key. Number 1 has key 0, number 2 has key 1, and every other number n has key `prio[n]+2`, where `prio[n]` is `req_prio[n*PRIO_W +: PRIO_W]`. When keys are equal, the lower exception number wins.
- R3: Numbers 0, 7, 8, 9, 10 and 13 are never entered, even when pending.
- R4: An entry raises `stk_req` and holds it until `stk_busy` is seen high. The vector read is issued only after `stk_busy` has fallen again.
- R5: The vector read address for exception n is `VT_BASE + 4*n`.
- R6: If a request with a strictly smaller key appears during the context push, the target switches to it. `stk_req` is not raised again, and only one vector read is issued, for the new number.
- R7: If a request with a strictly smaller key appears while a vector read is outstanding, the returned word is ignored. A second read is issued for the new number, the handler address comes from that second read, and the context push is still not repeated.
- R8: A request whose key is equal to or larger than the current target's key does not change the exception being entered.
- R9: If a request with a strictly smaller key than the active exception appears in the handler-start or running stage, a new context push is requested and the new exception's handler then starts.
- R10: While number 2 is active, no configurable-priority request starts a new entry. A pending number 1 does preempt it.
- R11: `hstart` is a one-cycle pulse. In that cycle, `act_num` holds the entered number and `handler_addr` holds the word returned by the accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pend | input | NUM_EXC | Pending flag per exception number |
| req_prio | input | NUM_EXC*PRIO_W | Priority field per exception number, lower is more urgent |
| stk_req | output | 1 | Context-push request to the save engine |
| stk_busy | input | 1 | Save engine is pushing context |
| mem_ren | output | 1 | Vector read strobe, one cycle |
| mem_raddr | output | ADDR_W | Vector read byte address |
| mem_rvalid | input | 1 | Read data valid, in request order |
| mem_rdata | input | DATA_W | Vector word returned |
| hstart | output | 1 | Handler start pulse |
| act_valid | output | 1 | An exception has been entered |
| act_num | output | $clog2(NUM_EXC) | Active exception number |
| handler_addr | output | DATA_W | Handler address of the active exception |

## Verification
The hardest case to reach is a late arrival that lands while a vector read is in flight. The stray word then comes back after the target has already changed, and a correct design must drop it and wait for the second read. The bench reaches this case by watching the read strobe at the ports and raising a more urgent request in the very next half-cycle, for every ordered pair of usable numbers. It repeats the same pair sweep with the injection made while `stk_busy` is high and again right after the handler-start pulse. This separates retargeting from preemption by counting push requests and reads.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned EXC_RESET = 1;
  localparam int unsigned EXC_NMI   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STACK,
    ST_FETCH,
    ST_HSTART,
    ST_RUN
  } seq_state_e;

  // Slot 0 holds the stack pointer; 7..10 and 13 carry no handler.
  function automatic bit vec_slot_usable(input int unsigned n);
    return (n != 0) && !(n >= 7 && n <= 10) && (n != 13);
  endfunction
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
  import exc_pkg::*;
#(
  parameter int NUM_EXC = 20,
  parameter int PRIO_W  = 3,
  localparam int NUM_W  = $clog2(NUM_EXC),
  localparam int KEY_W  = PRIO_W + 1
) (
  input  logic [NUM_EXC-1:0]        req_pend,
  input  logic [NUM_EXC*PRIO_W-1:0] req_prio,
  output logic                      pick_v,
  output logic [NUM_W-1:0]          pick_num,
  output logic [KEY_W-1:0]          pick_key
);
  logic [KEY_W-1:0]   key_a [NUM_EXC];
  logic [NUM_EXC-1:0] elig;

  generate
    for (genvar g = 0; g < NUM_EXC; g++) begin : g_key
      localparam bit USABLE = vec_slot_usable(g);
      assign key_a[g] = (g == EXC_RESET) ? KEY_W'(0) :
                        (g == EXC_NMI)   ? KEY_W'(1) :
                        KEY_W'(req_prio[g*PRIO_W +: PRIO_W]) + KEY_W'(2);
      assign elig[g]  = req_pend[g] & USABLE;
    end
  endgenerate

  // Strict compare in ascending order: ties go to the lower number.
  always_comb begin
    pick_v   = 1'b0;
    pick_num = '0;
    pick_key = '1;
    for (int i = 0; i < NUM_EXC; i++) begin
      if (elig[i] && (!pick_v || key_a[i] < pick_key)) begin
        pick_v   = 1'b1;
        pick_num = NUM_W'(i);
        pick_key = key_a[i];
      end
    end
  end

  always_comb begin
    if (pick_v) begin
      AST_PICK_USABLE: assert (vec_slot_usable(int'(pick_num))); // R3
    end
  end
endmodule

// File: rtl/exc_vec_reader.sv
module exc_vec_reader #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              drop,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_ren,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  logic outst_q, discard_q;

  assign rd_done = mem_rvalid & outst_q & ~discard_q & ~drop;
  assign rd_data = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ren   <= 1'b0;
      mem_raddr <= '0;
      outst_q   <= 1'b0;
      discard_q <= 1'b0;
    end else begin
      mem_ren <= 1'b0;
      if (mem_rvalid) begin
        outst_q   <= 1'b0;
        discard_q <= 1'b0;
      end else if (drop && outst_q) begin
        discard_q <= 1'b1;
      end
      if (go && !outst_q) begin
        mem_ren   <= 1'b1;
        mem_raddr <= addr;
        outst_q   <= 1'b1;
      end
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    mem_ren |=> !mem_ren); // R7
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          NUM_EXC = 20,
  parameter int          PRIO_W  = 3,
  parameter int          ADDR_W  = 32,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] VT_BASE = 32'h0000_0000,
  localparam int         NUM_W   = $clog2(NUM_EXC),
  localparam int         KEY_W   = PRIO_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_EXC-1:0]        req_pend,
  input  logic [NUM_EXC*PRIO_W-1:0] req_prio,
  output logic                      stk_req,
  input  logic                      stk_busy,
  output logic                      mem_ren,
  output logic [ADDR_W-1:0]         mem_raddr,
  input  logic                      mem_rvalid,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      hstart,
  output logic                      act_valid,
  output logic [NUM_W-1:0]          act_num,
  output logic [DATA_W-1:0]         handler_addr
);
  seq_state_e        state_q;
  logic [NUM_W-1:0]  tgt_num_q;
  logic [KEY_W-1:0]  tgt_key_q, act_key_q;
  logic              seen_busy_q;
  logic              pick_v, late, preempt, rd_done;
  logic [NUM_W-1:0]  pick_num;
  logic [KEY_W-1:0]  pick_key;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] vec_addr;

  exc_prio_pick #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) pick_i (
    .req_pend(req_pend), .req_prio(req_prio),
    .pick_v(pick_v), .pick_num(pick_num), .pick_key(pick_key)
  );

  assign late     = pick_v && (pick_key < tgt_key_q);
  assign preempt  = pick_v && (pick_key < act_key_q);
  assign vec_addr = ADDR_W'(VT_BASE) + (ADDR_W'(tgt_num_q) << 2);

  exc_vec_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rd_i (
    .clk(clk), .rst(rst),
    .go((state_q == ST_FETCH) && !late),
    .drop((state_q == ST_FETCH) && late),
    .addr(vec_addr),
    .mem_ren(mem_ren), .mem_raddr(mem_raddr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rd_done(rd_done), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      tgt_num_q    <= '0;
      tgt_key_q    <= '1;
      act_key_q    <= '1;
      act_num      <= '0;
      act_valid    <= 1'b0;
      handler_addr <= '0;
      hstart       <= 1'b0;
      stk_req      <= 1'b0;
      seen_busy_q  <= 1'b0;
    end else begin
      hstart <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (pick_v) begin
          tgt_num_q   <= pick_num;
          tgt_key_q   <= pick_key;
          stk_req     <= 1'b1;
          seen_busy_q <= 1'b0;
          state_q     <= ST_STACK;
        end
        ST_STACK: begin
          if (late) begin
            tgt_num_q <= pick_num;
            tgt_key_q <= pick_key;
          end
          if (stk_busy) begin
            seen_busy_q <= 1'b1;
            stk_req     <= 1'b0;
          end else if (seen_busy_q) begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (late) begin
            tgt_num_q <= pick_num;
            tgt_key_q <= pick_key;
          end else if (rd_done) begin
            handler_addr <= rd_data;
            act_num      <= tgt_num_q;
            act_key_q    <= tgt_key_q;
            act_valid    <= 1'b1;
            hstart       <= 1'b1;
            state_q      <= ST_HSTART;
          end
        end
        default: begin
          if (preempt) begin
            tgt_num_q   <= pick_num;
            tgt_key_q   <= pick_key;
            stk_req     <= 1'b1;
            seen_busy_q <= 1'b0;
            state_q     <= ST_STACK;
          end else begin
            state_q <= ST_RUN;
          end
        end
      endcase
    end
  end

  AST_NO_PUSH_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |-> !stk_req); // R6
  AST_HSTART_PULSE: assert property (@(posedge clk) disable iff (rst)
    hstart |=> !hstart); // R11
  AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    mem_ren |-> (((mem_raddr - ADDR_W'(VT_BASE)) >> 2) < ADDR_W'(NUM_EXC))); // R5
  AST_TARGET_NEVER_WORSE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STACK && $past(state_q) == ST_STACK) |-> (tgt_key_q <= $past(tgt_key_q))); // R8
  AST_NMI_HELD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && act_num == NUM_W'(EXC_NMI) && !req_pend[EXC_RESET]) |=> (state_q == ST_RUN)); // R10
endmodule

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  localparam int          NUM  = 20;
  localparam int          PW   = 3;
  localparam int          NW   = $clog2(NUM);
  localparam logic [31:0] BASE = 32'h0000_0400;
  localparam int          STK_LEN = 4;
  localparam int          LIMIT   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM-1:0]    pend = '0;
  logic [NUM*PW-1:0] prio = '0;
  logic stk_req, stk_busy, mem_ren, mem_rvalid, hstart, act_valid;
  logic [31:0] mem_raddr, mem_rdata, handler_addr;
  logic [NW-1:0] act_num;

  always #5 clk = ~clk;

  exc_entry_seq #(.NUM_EXC(NUM), .PRIO_W(PW), .VT_BASE(BASE)) dut_i (
    .clk(clk), .rst(rst), .req_pend(pend), .req_prio(prio),
    .stk_req(stk_req), .stk_busy(stk_busy),
    .mem_ren(mem_ren), .mem_raddr(mem_raddr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .hstart(hstart), .act_valid(act_valid), .act_num(act_num),
    .handler_addr(handler_addr)
  );

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return 32'hC0DE_0000 | (a & 32'h0000_FFFF) | 32'h1;
  endfunction
  function automatic logic [31:0] addr_of(input int n);
    return BASE + 32'(4 * n);
  endfunction
  function automatic bit legal(input int n);
    return (n != 0) && !(n >= 7 && n <= 10) && (n != 13) && (n < NUM);
  endfunction
  function automatic int key_of(input int n, input int p);
    return (n == 1) ? 0 : (n == 2) ? 1 : p + 2;
  endfunction
  function automatic int pa(input int a, input int b);
    return (a * 5 + b) % 8;
  endfunction
  function automatic int pb(input int a, input int b);
    return (b * 3 + a) % 8;
  endfunction

  // vector memory, fixed latency of three cycles
  logic v1, v2, v3;
  logic [31:0] a1, a2, a3;
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 0; v2 <= 0; v3 <= 0; a1 <= 0; a2 <= 0; a3 <= 0;
    end else begin
      v1 <= mem_ren; a1 <= mem_raddr;
      v2 <= v1; a2 <= a1; v3 <= v2; a3 <= a2;
    end
  end
  assign mem_rvalid = v3;
  assign mem_rdata  = word_of(a3);

  // register-save engine model
  logic busy_q;
  int   scnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 0; scnt <= 0;
    end else if (!busy_q && stk_req) begin
      busy_q <= 1; scnt <= STK_LEN;
    end else if (busy_q) begin
      if (scnt == 1) busy_q <= 0;
      scnt <= scnt - 1;
    end
  end
  assign stk_busy = busy_q;

  // port monitor
  int cyc, total, stk_cnt, ren_cnt, h_cnt, first_ren_cyc, first_fall_cyc;
  logic stk_req_d, busy_d;
  logic [31:0] first_raddr, last_addr;
  int last_num;
  int nchk = 0, nfail = 0;

  always_ff @(posedge clk) begin
    total <= total + 1;
    if (rst) begin
      cyc <= 1; stk_cnt <= 0; ren_cnt <= 0; h_cnt <= 0;
      first_ren_cyc <= 0; first_fall_cyc <= 0;
      stk_req_d <= 0; busy_d <= 0; first_raddr <= 0; last_addr <= 0; last_num <= -1;
    end else begin
      cyc <= cyc + 1;
      stk_req_d <= stk_req;
      busy_d <= stk_busy;
      if (stk_req && !stk_req_d) stk_cnt <= stk_cnt + 1;
      if (busy_d && !stk_busy && first_fall_cyc == 0) first_fall_cyc <= cyc;
      if (mem_ren) begin
        ren_cnt <= ren_cnt + 1;
        if (ren_cnt == 0) begin
          first_raddr <= mem_raddr;
          first_ren_cyc <= cyc;
        end
      end
      if (hstart) begin
        h_cnt <= h_cnt + 1;
        last_num <= int'(act_num);
        last_addr <= handler_addr;
      end
    end
  end

  initial total = 0;
  always @(posedge clk) begin
    if (total > LIMIT) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=%0d", total, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; pend = '0; prio = '0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic set_prio(input int n, input int p);
    prio[n*PW +: PW] = PW'(p);
  endtask

  task automatic wait_h(input int target, input int maxc);
    for (int i = 0; i < maxc && h_cnt < target; i++) @(negedge clk);
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 40 && !stk_busy; i++) @(negedge clk);
  endtask

  task automatic wait_ren();
    for (int i = 0; i < 60 && !mem_ren; i++) @(negedge clk);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(stk_req == 0,   "R1 stk_req", stk_req, 0);
    chk(mem_ren == 0,   "R1 mem_ren", mem_ren, 0);
    chk(hstart == 0,    "R1 hstart", hstart, 0);
    chk(act_valid == 0, "R1 act_valid", act_valid, 0);

    // single-request sweep over every number
    for (int n = 0; n < NUM; n++) begin
      do_reset();
      set_prio(n, (n * 3) % 8);
      pend[n] = 1'b1;
      wait_h(1, 60);
      if (legal(n)) begin
        chk(last_num == n, "R2 single winner", last_num, n);
        chk(first_raddr == addr_of(n), "R5 read address", first_raddr, addr_of(n));
        chk(last_addr == word_of(addr_of(n)), "R11 handler word", last_addr, word_of(addr_of(n)));
        chk(first_fall_cyc != 0 && first_ren_cyc > first_fall_cyc, "R4 read after push",
            first_ren_cyc, first_fall_cyc + 1);
        chk(stk_cnt == 1, "R4 one push", stk_cnt, 1);
      end else begin
        chk(stk_cnt == 0 && act_valid == 0, "R3 unusable slot ignored", stk_cnt, 0);
      end
    end

    // simultaneous pairs
    for (int a = 1; a < NUM; a++) begin
      for (int b = 1; b < NUM; b++) begin
        if (a != b && legal(a) && legal(b)) begin
          int ka, kb, w;
          ka = key_of(a, pa(a, b)); kb = key_of(b, pb(a, b));
          w = (kb < ka || (kb == ka && b < a)) ? b : a;
          do_reset();
          set_prio(a, pa(a, b)); set_prio(b, pb(a, b));
          pend[a] = 1'b1; pend[b] = 1'b1;
          wait_h(1, 60);
          chk(last_num == w, "R2 pair winner", last_num, w);
        end
      end
    end

    // late arrival during push, during read, and after handler start
    for (int mode = 0; mode < 3; mode++) begin
      for (int a = 1; a < NUM; a++) begin
        for (int b = 1; b < NUM; b++) begin
          if (a != b && legal(a) && legal(b)) begin
            bit beats;
            beats = key_of(b, pb(a, b)) < key_of(a, pa(a, b));
            do_reset();
            set_prio(a, pa(a, b)); set_prio(b, pb(a, b));
            pend[a] = 1'b1;
            if (mode == 0) wait_busy();
            else if (mode == 1) wait_ren();
            else wait_h(1, 60);
            pend[b] = 1'b1;
            if (mode < 2) begin
              wait_h(1, 80);
              if (beats) begin
                chk(last_num == b, mode == 0 ? "R6 retarget in push" : "R7 retarget in read", last_num, b);
                chk(stk_cnt == 1, mode == 0 ? "R6 single push" : "R7 single push", stk_cnt, 1);
                chk(ren_cnt == mode + 1, mode == 0 ? "R6 read count" : "R7 read count", ren_cnt, mode + 1);
                chk(last_addr == word_of(addr_of(b)), "R7 handler of new target", last_addr, word_of(addr_of(b)));
              end else begin
                chk(last_num == a && ren_cnt == 1, "R8 no retarget", last_num, a);
              end
            end else begin
              if (beats) begin
                wait_h(2, 80);
                chk(last_num == b && stk_cnt == 2, "R9 preempt with new push", last_num, b);
              end else begin
                repeat (40) @(negedge clk);
                chk(h_cnt == 1 && stk_cnt == 1, "R9 no preempt by weaker", stk_cnt, 1);
              end
            end
          end
        end
      end
    end

    // NMI held against every configurable request, then reset takes over
    do_reset();
    pend[2] = 1'b1;
    wait_h(1, 60);
    for (int n = 3; n < NUM; n++) begin
      set_prio(n, 0);
      if (legal(n)) pend[n] = 1'b1;
    end
    repeat (40) @(negedge clk);
    chk(stk_cnt == 1 && last_num == 2, "R10 NMI not preempted", last_num, 2);
    pend[1] = 1'b1;
    wait_h(2, 80);
    chk(last_num == 1 && stk_cnt == 2, "R10 reset preempts NMI", last_num, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule